// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 12-bit virtual address into a 16-bit physical address. The two most significant address bits pick one of four segments. The remaining ten bits are an offset into that segment. Each segment has three settings of its own: a base, a limit and a read-only flag. The offset is checked against the segment's limit. If the offset fits and the access is allowed, the physical address is the segment base plus the offset. Any other access returns a fault flag and no address.

Supervisor software loads the per-segment settings through a write port. That port only accepts writes while the privileged-mode input is high. A write attempted in user mode changes nothing and raises a one-cycle privilege-error flag.

Requests use a valid/ready handshake. Each accepted request produces exactly one registered result, one clock later.

Top module: `seg_xlate`

## Requirements
- R1: Virtual address bits [11:10] select the segment (0 to 3), and bits [9:0] are the offset within that segment.
- R2: For a legal access, `rsp_paddr` equals the segment base plus the offset, modulo 2^16. It is presented with `rsp_valid` high in the cycle after the clock edge that accepted the request.
- R3: When the offset is greater than or equal to the segment limit, `rsp_limit_fault` is set, `rsp_ro_fault` is clear and `rsp_paddr` is 0.
- R4: A write (`req_write`=1) inside the limit of a segment whose read-only flag is 1 sets `rsp_ro_fault` with `rsp_paddr` 0. Reads of that segment translate normally. A limit fault takes precedence over a read-only fault, so the two flags are never set together.
- R5: With `priv_mode`=1, a `cfg_wr_en` pulse loads base, limit and read-only flag into segment `cfg_seg`. The new values apply from the next accepted request on. A request accepted in the same cycle as the write is translated with the old values.
- R6: With `priv_mode`=0, a `cfg_wr_en` pulse leaves every segment setting unchanged. It sets `cfg_priv_err` for exactly one cycle after that edge.
- R7: After reset, segment k (k = 0, 1, 2) has base k*1024, limit 1024 and is writable. Segment 3 has limit 0, so every access to it gives a limit fault until software loads a non-zero limit.
- R8: `req_ready` is 0 during reset and 1 afterwards. `rsp_valid` is high for one cycle per accepted request and is otherwise low. Both fault flags are 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | High when the CPU runs privileged |
| cfg_wr_en | input | 1 | Segment setting write strobe |
| cfg_seg | input | 2 | Segment to write |
| cfg_base | input | 16 | New base address |
| cfg_limit | input | 11 | New limit (0 to 1024) |
| cfg_readonly | input | 1 | New read-only flag |
| cfg_priv_err | output | 1 | Pulse: write attempted in user mode |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator accepts requests |
| req_vaddr | input | 12 | Virtual address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_limit_fault | output | 1 | Offset outside segment limit |
| rsp_ro_fault | output | 1 | Write to read-only segment |

## Verification
A setting write and a translation of the same segment can land on the same clock edge. The bench provokes this by driving `cfg_wr_en` and `req_valid` together, both aimed at segment 2. It judges the outcome by two results. The request in that edge must carry the old base. The request that follows must carry the new one. A user-mode write is likewise issued just before a translation of the targeted segment. That translation must show the old mapping, and `cfg_priv_err` must pulse.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int DEF_VA_W  = 12;
  localparam int DEF_SEG_W = 2;
  localparam int DEF_PA_W  = 16;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_RO    = 2'd2
  } flt_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 2,
  parameter int OFF_W = 10,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             priv,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_seg,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W:0]   cfg_limit,
  input  logic             cfg_ro,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W:0]   rd_limit,
  output logic             rd_ro,
  output logic             priv_err
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int LIM_W = OFF_W + 1;

  logic [NSEG-1:0][PA_W-1:0]  base_q;
  logic [NSEG-1:0][LIM_W-1:0] limit_q;
  logic [NSEG-1:0]            ro_q;
  logic                       wr_ok;

  assign wr_ok = cfg_we && priv;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [PA_W-1:0]  RST_BASE  = PA_W'(g << OFF_W);
    localparam logic [LIM_W-1:0] RST_LIMIT = (g < NSEG - 1) ? LIM_W'(1 << OFF_W) : LIM_W'(0);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= RST_BASE;
        limit_q[g] <= RST_LIMIT;
        ro_q[g]    <= 1'b0;
      end else if (wr_ok && cfg_seg == SEG_W'(g)) begin
        base_q[g]  <= cfg_base;
        limit_q[g] <= cfg_limit;
        ro_q[g]    <= cfg_ro;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) priv_err <= 1'b0;
    else     priv_err <= cfg_we && !priv;
  end

  assign rd_base  = base_q[rd_seg];
  assign rd_limit = limit_q[rd_seg];
  assign rd_ro    = ro_q[rd_seg];

  AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !priv) |=> ($stable(base_q) && $stable(limit_q) && $stable(ro_q))); // R6
  AST_PRIV_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    priv_err |-> $past(cfg_we && !priv)); // R6
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int PA_W  = 16
) (
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W:0]   limit,
  input  logic             ro,
  input  logic [OFF_W-1:0] offset,
  input  logic             is_write,
  output logic [PA_W-1:0]  paddr,
  output flt_kind_e        kind
);
  logic [OFF_W:0] off_ext;
  logic           over;
  logic           ro_hit;

  assign off_ext = {1'b0, offset};
  assign over    = off_ext >= limit;
  assign ro_hit  = is_write && ro;

  always_comb begin
    if (over) begin
      kind  = FLT_LIMIT;
      paddr = '0;
    end else if (ro_hit) begin
      kind  = FLT_RO;
      paddr = '0;
    end else begin
      kind  = FLT_NONE;
      paddr = base + PA_W'(offset);
    end
  end

  always_comb begin
    AST_NO_ADDR_ON_FAULT: assert (kind == FLT_NONE || paddr == '0); // R3
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int SEG_W = DEF_SEG_W,
  parameter int PA_W  = DEF_PA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_mode,
  input  logic              cfg_wr_en,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [VA_W-SEG_W:0] cfg_limit,
  input  logic              cfg_readonly,
  output logic              cfg_priv_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_limit_fault,
  output logic              rsp_ro_fault
);
  localparam int OFF_W = VA_W - SEG_W;

  logic [SEG_W-1:0] seg_sel;
  logic [OFF_W-1:0] offset;
  logic [PA_W-1:0]  sel_base;
  logic [OFF_W:0]   sel_limit;
  logic             sel_ro;
  logic [PA_W-1:0]  xl_paddr;
  flt_kind_e        xl_kind;
  logic             accept;

  assign seg_sel = req_vaddr[VA_W-1 -: SEG_W];
  assign offset  = req_vaddr[OFF_W-1:0];
  assign accept  = req_valid && req_ready;

  seg_regfile #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .priv     (priv_mode),
    .cfg_we   (cfg_wr_en),
    .cfg_seg  (cfg_seg),
    .cfg_base (cfg_base),
    .cfg_limit(cfg_limit),
    .cfg_ro   (cfg_readonly),
    .rd_seg   (seg_sel),
    .rd_base  (sel_base),
    .rd_limit (sel_limit),
    .rd_ro    (sel_ro),
    .priv_err (cfg_priv_err)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .base    (sel_base),
    .limit   (sel_limit),
    .ro      (sel_ro),
    .offset  (offset),
    .is_write(req_write),
    .paddr   (xl_paddr),
    .kind    (xl_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_paddr       <= '0;
      rsp_limit_fault <= 1'b0;
      rsp_ro_fault    <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_paddr       <= xl_paddr;
        rsp_limit_fault <= (xl_kind == FLT_LIMIT);
        rsp_ro_fault    <= (xl_kind == FLT_RO);
      end else begin
        rsp_paddr       <= '0;
        rsp_limit_fault <= 1'b0;
        rsp_ro_fault    <= 1'b0;
      end
    end
  end

  AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rsp_limit_fault && rsp_ro_fault)); // R4
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready)); // R8
  AST_FLAGS_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    (rsp_limit_fault || rsp_ro_fault) |-> rsp_valid); // R8
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_limit_fault || rsp_ro_fault) |-> (rsp_paddr == '0)); // R3
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_mode = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_seg = '0;
  logic [15:0] cfg_base = '0;
  logic [10:0] cfg_limit = '0;
  logic        cfg_readonly = 1'b0;
  logic        cfg_priv_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_limit_fault;
  logic        rsp_ro_fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam int K_OK = 0, K_LIM = 1, K_RO = 2;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst(rst), .priv_mode(priv_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_seg(cfg_seg), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_readonly(cfg_readonly), .cfg_priv_err(cfg_priv_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_limit_fault(rsp_limit_fault), .rsp_ro_fault(rsp_ro_fault)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_rsp(string tag, int exp_pa, int kind);
    check(tag, "rsp_valid", int'(rsp_valid), 1);
    check(tag, "rsp_paddr", int'(rsp_paddr), exp_pa);
    check(tag, "limit_fault", int'(rsp_limit_fault), int'(kind == K_LIM));
    check(tag, "ro_fault", int'(rsp_ro_fault), int'(kind == K_RO));
  endtask

  task automatic xlate(string tag, logic [11:0] va, logic wr, int exp_pa, int kind);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(posedge clk); #1;
    check_rsp(tag, exp_pa, kind);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic cfg(string tag, logic pv, logic [1:0] s, logic [15:0] b,
                     logic [10:0] l, logic r, int exp_err);
    @(negedge clk);
    priv_mode = pv; cfg_wr_en = 1'b1; cfg_seg = s;
    cfg_base = b; cfg_limit = l; cfg_readonly = r;
    @(posedge clk); #1;
    check(tag, "cfg_priv_err", int'(cfg_priv_err), exp_err);
    @(negedge clk);
    cfg_wr_en = 1'b0; priv_mode = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8", "req_ready in reset", int'(req_ready), 0);
    check("R8", "rsp_valid in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R8", "req_ready after reset", int'(req_ready), 1);
    check("R6", "priv_err idle", int'(cfg_priv_err), 0);
  endtask

  task automatic t_default_map;
    xlate("R1", 12'h005, 1'b0, 'h0005, K_OK);
    xlate("R1", 12'h7FF, 1'b1, 'h07FF, K_OK);
    xlate("R2", 12'h923, 1'b0, 'h0923, K_OK);
    xlate("R7", 12'hC00, 1'b0, 0, K_LIM);
    xlate("R7", 12'hFFF, 1'b1, 0, K_LIM);
  endtask

  task automatic t_limits;
    cfg("R5", 1'b1, 2'd1, 16'h3000, 11'h100, 1'b0, 0);
    xlate("R5", 12'h4FF, 1'b0, 'h30FF, K_OK);
    xlate("R3", 12'h500, 1'b0, 0, K_LIM);
    xlate("R3", 12'h7FF, 1'b1, 0, K_LIM);
  endtask

  task automatic t_readonly;
    cfg("R4", 1'b1, 2'd0, 16'h1000, 11'h020, 1'b1, 0);
    xlate("R4", 12'h010, 1'b0, 'h1010, K_OK);
    xlate("R4", 12'h010, 1'b1, 0, K_RO);
    xlate("R4", 12'h020, 1'b1, 0, K_LIM);
  endtask

  task automatic t_user_write;
    cfg("R6", 1'b0, 2'd2, 16'hAAAA, 11'h001, 1'b1, 1);
    @(posedge clk); #1;
    check("R6", "priv_err one cycle", int'(cfg_priv_err), 0);
    xlate("R6", 12'h923, 1'b1, 'h0923, K_OK);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    priv_mode = 1'b1; cfg_wr_en = 1'b1; cfg_seg = 2'd2;
    cfg_base = 16'h8000; cfg_limit = 11'h400; cfg_readonly = 1'b0;
    req_valid = 1'b1; req_vaddr = 12'h805; req_write = 1'b0;
    @(posedge clk); #1;
    check_rsp("R5", 'h0805, K_OK);
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    xlate("R5", 12'h805, 1'b0, 'h8005, K_OK);
  endtask

  task automatic t_wrap;
    cfg("R2", 1'b1, 2'd2, 16'hFF00, 11'h400, 1'b0, 0);
    xlate("R2", 12'hA00, 1'b0, 'h0100, K_OK);
  endtask

  task automatic t_seg3_enable;
    cfg("R7", 1'b1, 2'd3, 16'h6000, 11'h001, 1'b0, 0);
    xlate("R7", 12'hC00, 1'b1, 'h6000, K_OK);
    xlate("R7", 12'hC01, 1'b0, 0, K_LIM);
  endtask

  task automatic t_idle;
    xlate("R8", 12'h000, 1'b0, 'h1000, K_OK);
    @(posedge clk); #1;
    check("R8", "rsp_valid idle", int'(rsp_valid), 0);
    check("R8", "limit_fault idle", int'(rsp_limit_fault), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    priv_mode = 1'b1;
    t_default_map();
    t_limits();
    t_readonly();
    t_user_write();
    t_same_cycle();
    t_wrap();
    t_seg3_enable();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule